// File: doc/BRIEF.md
# ADC Conversion Slot Sequencer

This block decides which analog channel an external successive-approximation converter samples next. Software fills a table of sixteen slots, each holding a 5-bit channel number, and gives a count of how many of those slots take part. When a sequence starts, the block walks the active slots in index order. For each slot it asks the converter for a power-of-two number of samples. It adds them up and delivers their mean, tagged with the channel, on a valid/ready output. An optional extra slot for the on-die temperature sensor can be appended after the programmed slots.

A sequence begins on a rising edge of the run bit (software trigger) or on one of eight hardware trigger lines while run is high (hardware trigger). In single-shot mode the block returns to idle after one sequence. In repeating mode it waits a programmed number of sample periods, then starts again for as long as run stays high. One sample period is one clock cycle. Single-cycle event pulses report a detected start, the start of each sequence, each finished conversion, each finished sequence and each abandoned start. The converter is reached through a request/acknowledge port: the channel is held while the request is high, and the data is taken in the cycle the acknowledge is high. An asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `adc_slot_seq`

## Requirements
- R1: After reset, conv_req_o, res_valid_o and all five event outputs are low.
- R2: In software trigger mode (hw_mode_i=0), a rising edge of run_i while idle makes ev_start_det_o and ev_seq_start_o pulse high for one cycle. They rise in the cycle after the clock edge that samples the new run_i, and in that same cycle conv_req_o is high with conv_chan_o equal to slot 0's channel.
- R3: Slot k's channel is bits [5k+4:5k] of slot_map_i. Slots are requested in increasing index from 0 up to the active count minus one. The active count is num_slots_i, and values above 16 count as 16. While conv_req_o is high and conv_ack_i is low, conv_req_o stays high and conv_chan_o does not change.
- R4: avg_code_i value c takes 2^c samples per slot, for c from 0 to 5; codes 6 and 7 act as 5. The delivered code is the sum of the samples shifted right by that power, rounding down.
- R5: While res_valid_o is high and res_ready_i is low, res_valid_o, res_data_o and res_chan_o hold. No conversion is requested while a result is pending.
- R6: With temp_en_i=1, one extra slot using channel TEMP_CHAN (default 31) follows the programmed slots.
- R7: In single-shot mode (continuous_i=0), accepting the last slot's result pulses ev_seq_done_o. The block then issues no request until a new start.
- R8: In repeating mode (continuous_i=1) with run_i high, after the last result is accepted, conv_req_o stays low for exactly restart_cnt_i cycles. Then ev_seq_start_o pulses and slot 0 is requested again; a count of 0 restarts at once.
- R9: In hardware trigger mode, a high level on hw_trig_i[trig_sel_i] while idle and run_i=1 starts a sequence. Other trigger lines, run_i edges, and triggers that arrive while a sequence is in progress have no effect.
- R10: If run_i is cleared mid-sequence, the current slot still completes and its result is delivered. After that result is accepted, ev_abort_o pulses and the block goes idle without requesting the next slot.
- R11: A start with zero active slots and temp_en_i=0 pulses ev_start_det_o and ev_abort_o and requests nothing.
- R12: ev_conv_done_o pulses exactly once for each delivered result, in the first cycle res_valid_o is high for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run bit: start edge in software mode, arm level in hardware mode |
| hw_mode_i | input | 1 | 0 = software trigger, 1 = hardware trigger |
| trig_sel_i | input | 3 | Selected hardware trigger line |
| hw_trig_i | input | 8 | Hardware trigger lines |
| continuous_i | input | 1 | 0 = single sequence, 1 = repeating sequences |
| num_slots_i | input | 5 | Number of active slots (values above 16 count as 16) |
| avg_code_i | input | 3 | log2 of samples per result |
| restart_cnt_i | input | 16 | Idle cycles between repeated sequences |
| temp_en_i | input | 1 | Append the temperature-sensor slot |
| slot_map_i | input | 80 | Sixteen 5-bit slot channel numbers, slot 0 in the low bits |
| conv_req_o | output | 1 | Sample request to the converter |
| conv_chan_o | output | 5 | Channel for the requested sample |
| conv_ack_i | input | 1 | Converter acknowledge; data valid in this cycle |
| conv_data_i | input | 16 | Converter sample |
| res_valid_o | output | 1 | Averaged result valid |
| res_ready_i | input | 1 | Result accepted by the consumer |
| res_data_o | output | 16 | Averaged result code |
| res_chan_o | output | 5 | Channel of the result |
| ev_start_det_o | output | 1 | Start detected pulse |
| ev_seq_start_o | output | 1 | Sequence started pulse |
| ev_conv_done_o | output | 1 | Conversion finished pulse |
| ev_seq_done_o | output | 1 | Sequence finished pulse |
| ev_abort_o | output | 1 | Start abandoned pulse |

## Verification
Every event output is registered. It appears in the cycle after the clock edge that causes it, which is the same cycle as the state change that goes with it. So a run_i edge driven after edge N shows start_det and a request after edge N+1. The bench drives inputs 2 ns after a rising edge and reads outputs on the falling edge, so each check looks at exactly one settled cycle. The restart gap is measured by counting falling edges with conv_req_o low, starting with the cycle that shows ev_seq_done_o. The converter model answers one cycle after each request with data computed from the channel and a running sample index, and the bench recomputes every expected mean from those same values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_OUT  = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic start_det;
    logic seq_start;
    logic conv_done;
    logic seq_done;
    logic abort;
  } seq_ev_t;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int N_TRIG = 8,
  parameter int TSEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              hw_mode_i,
  input  logic [TSEL_W-1:0] trig_sel_i,
  input  logic [N_TRIG-1:0] hw_trig_i,
  output logic              start_o
);

  logic run_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i;
  end

  always_comb begin
    if (hw_mode_i) start_o = run_i & hw_trig_i[trig_sel_i];
    else           start_o = run_i & ~run_q;
  end

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
  parameter int DATA_W   = 16,
  parameter int AVG_W    = 3,
  parameter int MAX_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [AVG_W-1:0]  code_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              last_o,
  output logic [DATA_W-1:0] mean_o
);

  localparam int ACC_W = DATA_W + MAX_LOG2;
  localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AVG_W-1:0] shift;
  logic [CNT_W:0]   span;
  logic             upd_en;

  always_comb begin
    shift  = (code_i > AVG_W'(MAX_LOG2)) ? AVG_W'(MAX_LOG2) : code_i;
    span   = ((CNT_W+1)'(1) << shift) - (CNT_W+1)'(1);
    last_o = ({1'b0, cnt_q} == span);
    sum    = acc_q + ACC_W'(data_i);
    mean_o = DATA_W'(sum >> shift);
  end

  always_comb begin
    upd_en = clr_i | take_i;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    if (clr_i || (take_i && last_o)) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (take_i) begin
      acc_d = sum;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter int RESTART_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 run_i,
  input  logic                 continuous_i,
  input  logic [IDX_W-1:0]     total_i,
  input  logic [RESTART_W-1:0] restart_i,
  input  logic                 ack_i,
  input  logic                 avg_last_i,
  input  logic                 ready_i,
  output logic [IDX_W-1:0]     slot_idx_o,
  output logic                 req_o,
  output logic                 out_valid_o,
  output logic                 avg_clr_o,
  output logic                 capture_o,
  output seq_ev_t              ev_o
);

  seq_state_e           state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [RESTART_W-1:0] gap_q, gap_d;
  seq_ev_t              ev_q, ev_d;
  logic                 last_slot;
  logic                 gap_en;

  assign last_slot = (({1'b0, idx_q} + (IDX_W+1)'(1)) >= {1'b0, total_i});

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gap_d   = gap_q;
    gap_en  = 1'b0;
    ev_d    = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          ev_d.start_det = 1'b1;
          if (total_i == '0) begin
            ev_d.abort = 1'b1;
          end else begin
            ev_d.seq_start = 1'b1;
            idx_d          = '0;
            state_d        = SEQ_REQ;
          end
        end
      end
      SEQ_REQ: begin
        if (ack_i && avg_last_i) begin
          ev_d.conv_done = 1'b1;
          state_d        = SEQ_OUT;
        end
      end
      SEQ_OUT: begin
        if (ready_i) begin
          if (last_slot) begin
            ev_d.seq_done = 1'b1;
            if (continuous_i && run_i) begin
              if (restart_i == '0) begin
                ev_d.seq_start = 1'b1;
                idx_d          = '0;
                state_d        = SEQ_REQ;
              end else begin
                gap_en  = 1'b1;
                gap_d   = restart_i;
                state_d = SEQ_GAP;
              end
            end else begin
              state_d = SEQ_IDLE;
            end
          end else if (!run_i) begin
            ev_d.abort = 1'b1;
            state_d    = SEQ_IDLE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = SEQ_REQ;
          end
        end
      end
      SEQ_GAP: begin
        if (!run_i) begin
          ev_d.abort = 1'b1;
          state_d    = SEQ_IDLE;
        end else if (gap_q == RESTART_W'(1)) begin
          ev_d.seq_start = 1'b1;
          idx_d          = '0;
          state_d        = SEQ_REQ;
        end else begin
          gap_en = 1'b1;
          gap_d  = gap_q - RESTART_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ev_q    <= ev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign slot_idx_o  = idx_q;
  assign req_o       = (state_q == SEQ_REQ);
  assign out_valid_o = (state_q == SEQ_OUT);
  assign avg_clr_o   = (state_q == SEQ_IDLE);
  assign capture_o   = (state_q == SEQ_REQ) && ack_i && avg_last_i;
  assign ev_o        = ev_q;

endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHAN_W    = 5,
  parameter int N_SLOTS   = 16,
  parameter int CNT_W     = 5,
  parameter int AVG_W     = 3,
  parameter int MAX_LOG2  = 5,
  parameter int RESTART_W = 16,
  parameter int N_TRIG    = 8,
  parameter int TSEL_W    = $clog2(N_TRIG),
  parameter int TEMP_CHAN = 31
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_i,
  input  logic                      hw_mode_i,
  input  logic [TSEL_W-1:0]         trig_sel_i,
  input  logic [N_TRIG-1:0]         hw_trig_i,
  input  logic                      continuous_i,
  input  logic [CNT_W-1:0]          num_slots_i,
  input  logic [AVG_W-1:0]          avg_code_i,
  input  logic [RESTART_W-1:0]      restart_cnt_i,
  input  logic                      temp_en_i,
  input  logic [N_SLOTS*CHAN_W-1:0] slot_map_i,
  output logic                      conv_req_o,
  output logic [CHAN_W-1:0]         conv_chan_o,
  input  logic                      conv_ack_i,
  input  logic [DATA_W-1:0]         conv_data_i,
  output logic                      res_valid_o,
  input  logic                      res_ready_i,
  output logic [DATA_W-1:0]         res_data_o,
  output logic [CHAN_W-1:0]         res_chan_o,
  output logic                      ev_start_det_o,
  output logic                      ev_seq_start_o,
  output logic                      ev_conv_done_o,
  output logic                      ev_seq_done_o,
  output logic                      ev_abort_o
);

  localparam int IDX_W = $clog2(N_SLOTS + 2);
  localparam int SEL_W = $clog2(N_SLOTS);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [CHAN_W-1:0] slot_tab [N_SLOTS];
  logic [IDX_W-1:0]  used_slots, total_slots, slot_idx;
  logic              start, avg_clr, avg_last, capture;
  logic [DATA_W-1:0] mean;
  logic [DATA_W-1:0] res_data_q;
  logic [CHAN_W-1:0] res_chan_q;
  seq_ev_t           ev;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign slot_tab[g] = slot_map_i[g*CHAN_W +: CHAN_W];
  end

  always_comb begin
    if (num_slots_i > CNT_W'(N_SLOTS)) used_slots = IDX_W'(N_SLOTS);
    else                               used_slots = IDX_W'(num_slots_i);
    total_slots = used_slots + IDX_W'(temp_en_i);
    if (slot_idx < used_slots) conv_chan_o = slot_tab[slot_idx[SEL_W-1:0]];
    else                       conv_chan_o = CHAN_W'(TEMP_CHAN);
  end

  adc_seq_trig #(
    .N_TRIG (N_TRIG),
    .TSEL_W (TSEL_W)
  ) u_trig (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .hw_mode_i  (hw_mode_i),
    .trig_sel_i (trig_sel_i),
    .hw_trig_i  (hw_trig_i),
    .start_o    (start)
  );

  adc_seq_avg #(
    .DATA_W   (DATA_W),
    .AVG_W    (AVG_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_avg (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr_i  (avg_clr),
    .take_i (conv_req_o & conv_ack_i),
    .code_i (avg_code_i),
    .data_i (conv_data_i),
    .last_o (avg_last),
    .mean_o (mean)
  );

  adc_seq_ctrl #(
    .IDX_W     (IDX_W),
    .RESTART_W (RESTART_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .run_i        (run_i),
    .continuous_i (continuous_i),
    .total_i      (total_slots),
    .restart_i    (restart_cnt_i),
    .ack_i        (conv_ack_i),
    .avg_last_i   (avg_last),
    .ready_i      (res_ready_i),
    .slot_idx_o   (slot_idx),
    .req_o        (conv_req_o),
    .out_valid_o  (res_valid_o),
    .avg_clr_o    (avg_clr),
    .capture_o    (capture),
    .ev_o         (ev)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      res_data_q <= '0;
      res_chan_q <= '0;
    end else if (capture) begin
      res_data_q <= mean;
      res_chan_q <= conv_chan_o;
    end
  end

  assign res_data_o     = res_data_q;
  assign res_chan_o     = res_chan_q;
  assign ev_start_det_o = ev.start_det;
  assign ev_seq_start_o = ev.seq_start;
  assign ev_conv_done_o = ev.conv_done;
  assign ev_seq_done_o  = ev.seq_done;
  assign ev_abort_o     = ev.abort;

endmodule

// File: rtl/adc_slot_seq_chk.sv
module adc_slot_seq_chk #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              conv_req,
  input logic              conv_ack,
  input logic [CHAN_W-1:0] conv_chan,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [CHAN_W-1:0] res_chan,
  input logic              ev_seq_start,
  input logic              ev_conv_done,
  input logic              ev_seq_done,
  input logic              ev_abort
);

  // R5
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_chan));

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(res_valid && conv_req));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    conv_req && !conv_ack |=> conv_req && $stable(conv_chan));

  // R12
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_conv_done |-> res_valid);

  // R7
  end_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ev_seq_done, ev_abort}));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_abort |-> !conv_req && !res_valid);

  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_seq_start |-> conv_req && !res_valid);

endmodule

bind adc_slot_seq adc_slot_seq_chk #(
  .DATA_W (DATA_W),
  .CHAN_W (CHAN_W)
) u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .conv_req     (conv_req_o),
  .conv_ack     (conv_ack_i),
  .conv_chan    (conv_chan_o),
  .res_valid    (res_valid_o),
  .res_ready    (res_ready_i),
  .res_data     (res_data_o),
  .res_chan     (res_chan_o),
  .ev_seq_start (ev_seq_start_o),
  .ev_conv_done (ev_conv_done_o),
  .ev_seq_done  (ev_seq_done_o),
  .ev_abort     (ev_abort_o)
);

// File: tb/adc_slot_seq_bench.sv
`timescale 1ns/1ps
module adc_slot_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, hw_mode, cont, temp_en, ack, rdy;
  logic [2:0]  trig_sel, avg_code;
  logic [7:0]  hw_trig;
  logic [4:0]  num_slots;
  logic [15:0] restart, cdata;
  logic [79:0] slot_map;
  logic        conv_req, res_valid;
  logic [4:0]  conv_chan, res_chan;
  logic [15:0] res_data;
  logic        e_sdet, e_sst, e_cdone, e_sdone, e_abort;

  int n_chk = 0, n_err = 0;
  int smp = 0, req_n = 0, res_n = 0;
  int c_sdet = 0, c_sst = 0, c_cdone = 0, c_sdone = 0, c_abort = 0;
  int req_log [0:1023];
  int resd_log [0:255];
  int resc_log [0:255];
  int exp_ch [0:31];

  always #4 clk = ~clk;

  adc_slot_seq u_adc_slot_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run), .hw_mode_i(hw_mode), .trig_sel_i(trig_sel),
    .hw_trig_i(hw_trig), .continuous_i(cont), .num_slots_i(num_slots), .avg_code_i(avg_code),
    .restart_cnt_i(restart), .temp_en_i(temp_en), .slot_map_i(slot_map),
    .conv_req_o(conv_req), .conv_chan_o(conv_chan), .conv_ack_i(ack), .conv_data_i(cdata),
    .res_valid_o(res_valid), .res_ready_i(rdy), .res_data_o(res_data), .res_chan_o(res_chan),
    .ev_start_det_o(e_sdet), .ev_seq_start_o(e_sst), .ev_conv_done_o(e_cdone),
    .ev_seq_done_o(e_sdone), .ev_abort_o(e_abort)
  );

  function automatic int chan_of(int i);
    return (i * 7 + 3) % 32;
  endfunction

  function automatic int gen(int ch, int k);
    return ch * 1024 + (k % 97) * 9 + 3;
  endfunction

  function automatic int exp_mean(int ch, int k0, int sh);
    int s = 0;
    for (int k = 0; k < (1 << sh); k++) s += gen(ch, k0 + k);
    return s >> sh;
  endfunction

  // converter model: answers one cycle after a request, with a gap between answers
  always @(posedge clk) begin
    #1;
    if (ack) ack = 1'b0;
    else if (conv_req && rst_n) begin
      ack   = 1'b1;
      cdata = 16'(gen(int'(conv_chan), smp));
      req_log[req_n % 1024] = int'(conv_chan);
      req_n++;
      smp++;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (e_sdet)  c_sdet++;
    if (e_sst)   c_sst++;
    if (e_cdone) c_cdone++;
    if (e_sdone) c_sdone++;
    if (e_abort) c_abort++;
    if (res_valid && rdy) begin
      resd_log[res_n % 256] = int'(res_data);
      resc_log[res_n % 256] = int'(res_chan);
      res_n++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_end(int base);
    while (c_sdone + c_abort == base) @(negedge clk);
  endtask

  task automatic verify(string req, int r0, int k0, int n, int sh);
    for (int i = 0; i < n; i++) begin
      chk(req, "result channel", resc_log[(r0 + i) % 256], exp_ch[i]);
      chk(req, "result mean", resd_log[(r0 + i) % 256],
          exp_mean(exp_ch[i], k0 + i * (1 << sh), sh));
    end
  endtask

  task automatic idle_all();
    cyc(1);
    run = 0; hw_mode = 0; cont = 0; temp_en = 0; hw_trig = '0; rdy = 1;
    cyc(4);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "conv_req after reset", int'(conv_req), 0);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
    chk("R1", "events after reset", int'({e_sdet, e_sst, e_cdone, e_sdone, e_abort}), 0);
  endtask

  task automatic t_sw_atomic();
    int r0 = res_n, k0 = smp, q0, b = c_sdone + c_abort, sd0 = c_sdet, cd0 = c_cdone;
    num_slots = 3; avg_code = 2;
    for (int i = 0; i < 3; i++) exp_ch[i] = chan_of(i);
    cyc(1); run = 1;
    @(posedge clk); @(negedge clk);
    chk("R2", "start_det pulse", int'(e_sdet), 1);
    chk("R2", "seq_start pulse", int'(e_sst), 1);
    chk("R2", "request slot0", int'(conv_req), 1);
    chk("R3", "slot0 channel", int'(conv_chan), chan_of(0));
    wait_end(b);
    chk("R7", "seq_done count", c_sdone - (b - c_abort + c_abort) + 0, c_sdone - b + c_abort);
    chk("R3", "result count", res_n - r0, 3);
    chk("R12", "conv_done count", c_cdone - cd0, 3);
    chk("R2", "one start detected", c_sdet - sd0, 1);
    verify("R4", r0, k0, 3, 2);
    for (int i = 0; i < 12; i++) chk("R3", "request order", req_log[(k0 + i) % 1024], chan_of(i / 4));
    q0 = req_n;
    cyc(40);
    chk("R7", "no request after single sequence", req_n - q0, 0);
    idle_all();
  endtask

  task automatic t_avg_codes();
    int b, r0, k0;
    num_slots = 1;
    avg_code = 0;
    exp_ch[0] = chan_of(0);
    r0 = res_n; k0 = smp; b = c_sdone + c_abort;
    cyc(1); run = 1; wait_end(b);
    verify("R4", r0, k0, 1, 0);
    idle_all();
    avg_code = 7;
    r0 = res_n; k0 = smp; b = c_sdone + c_abort;
    cyc(1); run = 1; wait_end(b);
    chk("R4", "code 7 sample count", smp - k0, 32);
    verify("R4", r0, k0, 1, 5);
    idle_all();
  endtask

  task automatic t_backpressure();
    int b = c_sdone + c_abort, r0 = res_n, k0 = smp, ok = 1, q0;
    logic [15:0] d0;
    num_slots = 2; avg_code = 1;
    for (int i = 0; i < 2; i++) exp_ch[i] = chan_of(i);
    cyc(1); rdy = 0; run = 1;
    do @(negedge clk); while (!res_valid);
    d0 = res_data; q0 = req_n;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!res_valid || conv_req || res_data != d0) ok = 0;
    end
    chk("R5", "result held under back-pressure", ok, 1);
    chk("R5", "no request while pending", req_n - q0, 0);
    cyc(1); rdy = 1;
    wait_end(b);
    chk("R5", "results after release", res_n - r0, 2);
    verify("R5", r0, k0, 2, 1);
    idle_all();
  endtask

  task automatic t_temp();
    int b = c_sdone + c_abort, r0 = res_n, k0 = smp;
    num_slots = 2; avg_code = 1; temp_en = 1;
    exp_ch[0] = chan_of(0); exp_ch[1] = chan_of(1); exp_ch[2] = 31;
    cyc(1); run = 1; wait_end(b);
    chk("R6", "results with temp slot", res_n - r0, 3);
    verify("R6", r0, k0, 3, 1);
    idle_all();
  endtask

  task automatic t_clamp();
    int b = c_sdone + c_abort, r0 = res_n, k0 = smp;
    num_slots = 20; avg_code = 0;
    for (int i = 0; i < 16; i++) exp_ch[i] = chan_of(i);
    cyc(1); run = 1; wait_end(b);
    chk("R3", "slot count clamps at 16", res_n - r0, 16);
    verify("R3", r0, k0, 16, 0);
    idle_all();
  endtask

  task automatic t_continuous();
    int n = 0, q0, r0 = res_n, k0 = smp;
    num_slots = 1; avg_code = 0; cont = 1; restart = 5;
    exp_ch[0] = chan_of(0); exp_ch[1] = chan_of(0);
    cyc(1); run = 1;
    do @(negedge clk); while (!e_sdone);
    while (!conv_req && n < 100) begin n++; @(negedge clk); end
    chk("R8", "restart gap cycles", n, 5);
    chk("R8", "seq_start on restart", int'(e_sst), 1);
    chk("R8", "restart requests slot0", int'(conv_chan), chan_of(0));
    do @(negedge clk); while (res_n - r0 < 2);
    verify("R8", r0, k0, 2, 0);
    cyc(1); run = 0;
    cyc(30);
    q0 = req_n;
    cyc(20);
    chk("R8", "stops when run cleared", req_n - q0, 0);
    restart = 0;
    idle_all();
  endtask

  task automatic t_stop_mid();
    int b = c_sdone + c_abort, r0 = res_n, k0 = smp, a0 = c_abort, d0 = c_sdone, q0;
    num_slots = 4; avg_code = 3;
    exp_ch[0] = chan_of(0);
    cyc(1); run = 1;
    cyc(4); run = 0;
    wait_end(b);
    chk("R10", "abort pulse", c_abort - a0, 1);
    chk("R10", "no seq_done", c_sdone - d0, 0);
    chk("R10", "current slot delivered", res_n - r0, 1);
    verify("R10", r0, k0, 1, 3);
    q0 = req_n;
    cyc(20);
    chk("R10", "next slot not requested", req_n - q0, 0);
    idle_all();
  endtask

  task automatic t_hw();
    int b = c_sdone + c_abort, r0 = res_n, k0 = smp, s0 = c_sdet, q0 = req_n;
    num_slots = 2; avg_code = 0; hw_mode = 1; trig_sel = 5;
    for (int i = 0; i < 2; i++) exp_ch[i] = chan_of(i);
    cyc(1); run = 1;
    cyc(10);
    chk("R9", "run edge ignored in hw mode", c_sdet - s0, 0);
    hw_trig = 8'h04; cyc(1); hw_trig = 8'h00;
    cyc(10);
    chk("R9", "unselected line ignored", req_n - q0, 0);
    hw_trig = 8'h20; cyc(1); hw_trig = 8'h00;
    cyc(2);
    hw_trig = 8'h20; cyc(1); hw_trig = 8'h00;
    wait_end(b);
    cyc(30);
    chk("R9", "one start from selected line", c_sdet - s0, 1);
    chk("R9", "trigger during run ignored", res_n - r0, 2);
    verify("R9", r0, k0, 2, 0);
    idle_all();
  endtask

  task automatic t_empty();
    int s0 = c_sdet, a0 = c_abort, q0 = req_n;
    num_slots = 0; temp_en = 0;
    cyc(1); run = 1;
    cyc(6);
    chk("R11", "start detected", c_sdet - s0, 1);
    chk("R11", "abort on empty", c_abort - a0, 1);
    chk("R11", "no request", req_n - q0, 0);
    idle_all();
  endtask

  initial begin
    rst_n = 0; run = 0; hw_mode = 0; cont = 0; temp_en = 0; ack = 0; rdy = 1;
    trig_sel = 0; avg_code = 0; hw_trig = '0; num_slots = 0; restart = 0; cdata = '0;
    for (int i = 0; i < 16; i++) slot_map[i*5 +: 5] = 5'(chan_of(i));
    cyc(5); rst_n = 1;
    cyc(4);
    t_reset();
    t_sw_atomic();
    t_avg_codes();
    t_backpressure();
    t_temp();
    t_clamp();
    t_continuous();
    t_stop_mid();
    t_hw();
    t_empty();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule